// File: doc/BRIEF.md
# Multi-Mode Compare/Capture Channel

This block is one 16-bit channel that hangs off a free-running time base counter shared with other channels. Software picks one of four modes through a small control register: edge capture, where a selected transition on the channel pin latches the current count; timer compare, where a count equal to a programmed 16-bit value raises an event flag; toggle output, where the same match also inverts the pin drive; and pulse width modulation, where the pin level comes from comparing the counter's low byte with a duty byte.

The compare value and the captured value share one 16-bit register, written one byte at a time. Writing the low byte suspends matching until the high byte arrives, so a 16-bit update can never produce a half-written match. In PWM mode the high byte of that register is the duty byte. A shadow copy of it is what the comparator sees. The shadow reloads only when the low byte of the count wraps, so the waveform never glitches mid-period. The event flag feeds a request line that the surrounding logic merges with other sources. Software clears it by writing zero.

Top module: `cc_channel`

## Requirements
- R1: After synchronous reset, `pin_out` is 0, `evt_flag` is 0, `cap_val` is 0, the mode is capture with both edge enables off, and matching is disabled until a high-byte write.
- R2: With `ctl_wdata[1:0]`=00 (capture) and `ctl_wdata[2]`=1 (rising enable), a rising edge on `pin_in` passes two synchronizer flops. On the following clock, `cnt_val` is copied into `cap_val` and `evt_flag` is set. An edge whose enable bit is 0 changes neither `cap_val` nor `evt_flag`.
- R3: `ctl_wdata[3]` enables capture on falling edges. With both bits set, both edges capture. With only bit 3 set, rising edges are ignored.
- R4: With mode 01 (timer), `evt_flag` is set on the clock after a cycle where matching is enabled, `cnt_tick`=1 and `cnt_val` equals `cap_val`. Without `cnt_tick`, an equal count does not set the flag.
- R5: A write to `cmp_lo_we` loads `cap_val[7:0]` and disables matching. A write to `cmp_hi_we` loads `cap_val[15:8]` and re-enables matching.
- R6: With mode 10 (toggle), each match inverts `pin_out` and sets `evt_flag` on the same clock. A tick without a match leaves the pin alone.
- R7: With mode 11 (PWM), `pin_out` is registered each clock as 0 when `cnt_val[7:0]` is below the shadow duty, and 1 otherwise.
- R8: The shadow duty follows `cap_val[15:8]` whenever the mode is not PWM. In PWM mode it reloads only on a cycle with `cnt_tick`=1 and `cnt_val[7:0]`=8'hFF.
- R9: PWM mode never sets `evt_flag`, even when the count equals the register.
- R10: `flag_clr` clears `evt_flag` on the next clock. A capture or match event in the same cycle wins, and the flag stays 1.
- R11: `pin_out` changes only in toggle or PWM mode. `cap_val` changes only on a byte write or a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Shared time base count |
| cnt_tick | input | 1 | Count strobe, high in cycles where the count advances |
| pin_in | input | 1 | Asynchronous channel pin input for capture |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write data: [1:0] mode, [2] rising enable, [3] falling enable |
| cmp_lo_we | input | 1 | Write strobe for the low byte of the compare/capture register |
| cmp_hi_we | input | 1 | Write strobe for the high byte of the compare/capture register |
| cmp_wdata | input | 8 | Byte written to the compare/capture register |
| flag_clr | input | 1 | Software write of 0 to the event flag |
| pin_out | output | 1 | Registered channel pin drive |
| cap_val | output | 16 | Compare/capture register contents |
| evt_flag | output | 1 | Event flag, the channel's interrupt request |

## Verification
The checker watches, on every cycle, that the flag only falls after a clear, never rises in PWM mode and needs a count strobe in timer mode. It also checks that the pin moves only in toggle or PWM mode, that every toggle-mode pin change comes with the flag, and that the register changes only on writes or in capture mode. What the captured value is, which edges the enable bits admit, the low-byte write lock, the PWM level against the duty and the timing of the shadow reload can only be shown by the bench scenarios. Those run with directed corner cases and random compare and duty values.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    CC_CAPTURE = 2'b00,
    CC_TIMER   = 2'b01,
    CC_TOGGLE  = 2'b10,
    CC_PWM     = 2'b11
  } cc_mode_e;
endpackage

// File: rtl/cc_edge_sync.sv
// Synchronizes the pin and flags single-cycle rising/falling edges.
module cc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/cc_cmp_reg.sv
// Byte-written compare/capture register with a write lock on the low byte.
module cc_cmp_reg #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic [BW-1:0] wbyte,
  input  logic          cap_load,
  input  logic [W-1:0]  cap_data,
  input  logic [W-1:0]  cnt,
  input  logic          tick,
  output logic [W-1:0]  value,
  output logic          match
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      armed <= 1'b0;
    end else begin
      if (lo_we) value[BW-1:0] <= wbyte;
      if (hi_we) value[W-1:BW] <= wbyte;
      if (cap_load) value <= cap_data;
      if (hi_we)      armed <= 1'b1;
      else if (lo_we) armed <= 1'b0;
    end
  end

  assign match = armed && tick && (cnt == value);
endmodule

// File: rtl/cc_pwm.sv
// Shadowed duty byte and low-byte comparator.
module cc_pwm #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          tick,
  input  logic [BW-1:0] cnt_lo,
  input  logic [BW-1:0] duty,
  output logic          level
);
  logic [BW-1:0] shadow;
  logic          wrap;

  assign wrap = tick && (cnt_lo == {BW{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)                 shadow <= '0;
    else if (!active || wrap) shadow <= duty;
  end

  assign level = !(cnt_lo < shadow);
endmodule

// File: rtl/cc_channel.sv
module cc_channel #(
  parameter int CNT_W     = 16,
  parameter int SYNC_LEN  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   cnt_val,
  input  logic               cnt_tick,
  input  logic               pin_in,
  input  logic               ctl_we,
  input  logic [3:0]         ctl_wdata,
  input  logic               cmp_lo_we,
  input  logic               cmp_hi_we,
  input  logic [CNT_W/2-1:0] cmp_wdata,
  input  logic               flag_clr,
  output logic               pin_out,
  output logic [CNT_W-1:0]   cap_val,
  output logic               evt_flag
);
  import cc_pkg::*;

  localparam int BW = CNT_W / 2;

  cc_mode_e mode_q;
  logic     rise_en, fall_en;
  logic     rise, fall;
  logic     cap_evt, hit, raw_match, pwm_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= CC_CAPTURE;
      rise_en <= 1'b0;
      fall_en <= 1'b0;
    end else if (ctl_we) begin
      mode_q  <= cc_mode_e'(ctl_wdata[1:0]);
      rise_en <= ctl_wdata[2];
      fall_en <= ctl_wdata[3];
    end
  end

  cc_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .rise(rise), .fall(fall)
  );

  assign cap_evt = (mode_q == CC_CAPTURE) && ((rise && rise_en) || (fall && fall_en));

  cc_cmp_reg #(.W(CNT_W), .BW(BW)) u_reg (
    .clk(clk), .rst(rst),
    .lo_we(cmp_lo_we), .hi_we(cmp_hi_we), .wbyte(cmp_wdata),
    .cap_load(cap_evt), .cap_data(cnt_val),
    .cnt(cnt_val), .tick(cnt_tick),
    .value(cap_val), .match(raw_match)
  );

  assign hit = raw_match && (mode_q == CC_TIMER || mode_q == CC_TOGGLE);

  cc_pwm #(.BW(BW)) u_pwm (
    .clk(clk), .rst(rst),
    .active(mode_q == CC_PWM), .tick(cnt_tick),
    .cnt_lo(cnt_val[BW-1:0]), .duty(cap_val[CNT_W-1:BW]),
    .level(pwm_level)
  );

  always_ff @(posedge clk) begin
    if (rst)                   evt_flag <= 1'b0;
    else if (cap_evt || hit)   evt_flag <= 1'b1;
    else if (flag_clr)         evt_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                              pin_out <= 1'b0;
    else if (mode_q == CC_PWM)            pin_out <= pwm_level;
    else if (mode_q == CC_TOGGLE && hit)  pin_out <= ~pin_out;
  end
endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic             cnt_tick,
  input logic             cmp_lo_we,
  input logic             cmp_hi_we,
  input logic             flag_clr,
  input logic             pin_out,
  input logic [CNT_W-1:0] cap_val,
  input logic             evt_flag
);
  import cc_pkg::*;

  // R10: the flag only drops after a software clear
  a_r10_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(evt_flag) |-> $past(flag_clr));

  // R9: PWM mode never raises the flag
  a_r9_no_flag_in_pwm: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_flag) |-> ($past(mode) != CC_PWM));

  // R4: a timer-mode event needs the count strobe
  a_r4_tick_needed: assert property (@(posedge clk) disable iff (rst)
    ($rose(evt_flag) && $past(mode) == CC_TIMER) |-> $past(cnt_tick));

  // R6: every toggle-mode pin change comes with the flag
  a_r6_toggle_flags: assert property (@(posedge clk) disable iff (rst)
    (($past(mode) == CC_TOGGLE) && !$stable(pin_out)) |-> evt_flag);

  // R11: pin moves only in toggle or PWM mode
  a_r11_pin_mode: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_out) |-> ($past(mode) == CC_TOGGLE || $past(mode) == CC_PWM));

  // R11: register changes only on writes or in capture mode
  a_r11_reg_source: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap_val) |-> $past(cmp_lo_we || cmp_hi_we || mode == CC_CAPTURE));
endmodule

bind cc_channel cc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode_q), .cnt_tick(cnt_tick),
  .cmp_lo_we(cmp_lo_we), .cmp_hi_we(cmp_hi_we), .flag_clr(flag_clr),
  .pin_out(pin_out), .cap_val(cap_val), .evt_flag(evt_flag)
);

// File: tb/cc_channel_bench.sv
module cc_channel_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cnt_val = '0;
  logic        cnt_tick = 1'b0;
  logic        pin_in = 1'b0;
  logic        ctl_we = 1'b0;
  logic [3:0]  ctl_wdata = '0;
  logic        cmp_lo_we = 1'b0;
  logic        cmp_hi_we = 1'b0;
  logic [7:0]  cmp_wdata = '0;
  logic        flag_clr = 1'b0;
  logic        pin_out;
  logic [15:0] cap_val;
  logic        evt_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_channel u_cc_channel (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
    .pin_in(pin_in), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cmp_lo_we(cmp_lo_we), .cmp_hi_we(cmp_hi_we), .cmp_wdata(cmp_wdata),
    .flag_clr(flag_clr), .pin_out(pin_out), .cap_val(cap_val), .evt_flag(evt_flag)
  );

  function automatic logic pwm_exp(input logic [7:0] lo, input logic [7:0] duty);
    return (lo < duty) ? 1'b0 : 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    ctl_we = 1'b1; ctl_wdata = v; cyc(); ctl_we = 1'b0;
  endtask

  task automatic wr_lo(input logic [7:0] b);
    cmp_lo_we = 1'b1; cmp_wdata = b; cyc(); cmp_lo_we = 1'b0;
  endtask

  task automatic wr_hi(input logic [7:0] b);
    cmp_hi_we = 1'b1; cmp_wdata = b; cyc(); cmp_hi_we = 1'b0;
  endtask

  task automatic clr();
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
  endtask

  task automatic tick_at(input logic [15:0] c);
    cnt_val = c; cnt_tick = 1'b1; cyc(); cnt_tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed);
    @(negedge clk);
    cyc(3);
    rst = 1'b0;
    cyc();
    chk("R1 pin", pin_out, 0);
    chk("R1 flag", evt_flag, 0);
    chk("R1 reg", cap_val, 0);

    // R2: rising capture
    wr_ctl(4'b0100);
    cnt_val = 16'h1234; pin_in = 1'b1; cyc(4);
    chk("R2 rise capture", cap_val, 16'h1234);
    chk("R2 flag", evt_flag, 1);
    clr();
    chk("R10 clear", evt_flag, 0);
    cnt_val = 16'h5555; pin_in = 1'b0; cyc(4);
    chk("R2 falling ignored reg", cap_val, 16'h1234);
    chk("R2 falling ignored flag", evt_flag, 0);

    // R3: both edges, then falling only
    wr_ctl(4'b1100);
    cnt_val = 16'hABCD; pin_in = 1'b1; cyc(4);
    chk("R3 both rise", cap_val, 16'hABCD);
    clr();
    cnt_val = 16'h0F0F; pin_in = 1'b0; cyc(4);
    chk("R3 both fall", cap_val, 16'h0F0F);
    chk("R3 fall flag", evt_flag, 1);
    clr();
    wr_ctl(4'b1000);
    cnt_val = 16'h1111; pin_in = 1'b1; cyc(4);
    chk("R3 rise ignored", cap_val, 16'h0F0F);
    chk("R3 rise ignored flag", evt_flag, 0);
    cnt_val = 16'h2222; pin_in = 1'b0; cyc(4);
    chk("R3 fall only", cap_val, 16'h2222);
    clr();

    // R4: timer compare
    wr_ctl(4'b0001);
    cnt_val = 16'h0000;
    wr_lo(8'h34); wr_hi(8'h12);
    chk("R5 bytes loaded", cap_val, 16'h1234);
    cnt_val = 16'h1234; cyc();
    chk("R4 no tick no flag", evt_flag, 0);
    tick_at(16'h1234);
    chk("R4 match flag", evt_flag, 1);
    chk("R11 timer pin held", pin_out, 0);
    // R10: set wins over clear
    cnt_val = 16'h1234; cnt_tick = 1'b1; flag_clr = 1'b1; cyc();
    cnt_tick = 1'b0;
    chk("R10 set beats clear", evt_flag, 1);
    cyc();
    flag_clr = 1'b0;
    chk("R10 clear alone", evt_flag, 0);

    // R5: low-byte lock
    wr_lo(8'h99);
    tick_at(16'h1299);
    chk("R5 locked after low write", evt_flag, 0);
    wr_hi(8'h12);
    tick_at(16'h1299);
    chk("R5 unlocked by high write", evt_flag, 1);
    clr();

    // R4 random compares
    for (int k = 0; k < 16; k++) begin
      logic [15:0] v;
      logic        t;
      v = 16'($urandom);
      t = 1'($urandom);
      cnt_val = v ^ 16'h8001;
      wr_lo(v[7:0]); wr_hi(v[15:8]);
      cnt_val = v; cnt_tick = t; cyc(); cnt_tick = 1'b0;
      chk("R4 random match", evt_flag, t);
      clr();
    end

    // R6: toggle output
    wr_ctl(4'b0010);
    wr_lo(8'h00); wr_hi(8'h80);
    tick_at(16'h8000);
    chk("R6 toggle high", pin_out, 1);
    chk("R6 flag", evt_flag, 1);
    clr();
    tick_at(16'h8000);
    chk("R6 toggle low", pin_out, 0);
    clr();
    tick_at(16'h8001);
    chk("R6 no match keeps pin", pin_out, 0);
    chk("R6 no match no flag", evt_flag, 0);

    // R7/R8: PWM with duty 0x40 loaded outside PWM
    wr_hi(8'h40);
    clr();
    wr_ctl(4'b0011);
    cnt_val = 16'h0010; cyc();
    chk("R7 below duty low", pin_out, 0);
    cnt_val = 16'h0040; cyc();
    chk("R7 at duty high", pin_out, 1);
    wr_hi(8'h80);
    cnt_val = 16'h0050; cyc();
    chk("R8 old shadow kept", pin_out, 1);
    tick_at(16'h00FF);
    cnt_val = 16'h0050; cyc();
    chk("R8 reload on wrap", pin_out, 0);
    cnt_val = 16'h0090; cyc();
    chk("R7 above duty", pin_out, 1);
    tick_at(16'h8000);
    chk("R9 no flag in pwm", evt_flag, 0);
    chk("R7 zero low byte", pin_out, 0);

    // R7 random duty
    for (int k = 0; k < 12; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      wr_ctl(4'b0001);
      wr_hi(d);
      wr_ctl(4'b0011);
      for (int j = 0; j < 4; j++) begin
        logic [7:0] lo;
        lo = 8'($urandom);
        cnt_val = {8'h00, lo}; cyc();
        chk("R7 random pwm", pin_out, pwm_exp(lo, d));
      end
      chk("R9 random pwm no flag", evt_flag, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule